// File: doc/BRIEF.md
# Decode Group Steering with Sequenced Microcode Path

This block sits between an instruction window and a bank of decoders. Each cycle it looks at up to four instructions whose lengths are already known. Each instruction carries the number of micro-operations it expands into. The block then decides how many of them form this cycle's decode group.

The decoder slots are not alike. The head slot may take an instruction of one to four micro-operations. The trailing slots accept only single-micro-operation instructions. An instruction that expands into more micro-operations than the head slot can hold goes to a sequenced microcode path instead. That path issues its micro-operations four per cycle while the rest of decode waits.

The block drives a lane bundle with a valid bit and a micro-operation index for each lane. It also reports how many window entries the fetch buffer may pop this cycle.

Top module: `decGroupSteer`

## Requirements
- R1: Reset clears any microcode stream in progress. After reset, an instruction in the head slot that needs more than four micro-operations restarts its stream at micro-operation index 0.
- R2: At most four instructions are consumed per cycle. Lanes 4, 5 and 6 each carry the single micro-operation (index 0) of window entries 1, 2 and 3 respectively. An entry whose count is exactly 1 counts as simple.
- R3: A head instruction with a count from 1 to 4 sets lanes 0 to count-1 valid, with lane n carrying micro-operation index n.
- R4: A group ends just before the first trailing entry whose count is not 1. The consume output equals the number of instructions in the group, and the entry that ended the group becomes the head of a later cycle.
- R5: An entry with a count of zero is invalid. With such an entry at the head, no lane is valid and the consume output is 0.
- R6: A head count above 4 starts a microcode stream. The stream issues indices base to base+3 on lanes 0-3 per cycle, starting from base 0, and no trailing lane is valid. Consume is 0 on every cycle except the one carrying the last micro-operation, where it is 1.
- R7: While the stall input is high, the consume output is 0 and neither the group position nor the microcode progress advances. The same bundle is offered again once the stall drops.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge |
| rstN | input | 1 | Active-low synchronous reset |
| instUops | input | 4x6 | Micro-operation count per window entry. Entry 0 is the oldest; 0 means invalid |
| stallIn | input | 1 | Downstream hold request |
| uopValid | output | 7 | Lane valid bits. Lanes 0-3 belong to the head slot or microcode; lanes 4-6 belong to entries 1-3 |
| uopIdx | output | 7x6 | Micro-operation index within its instruction, per lane |
| consumeCnt | output | 3 | Number of window entries the fetch buffer pops this cycle |

## Verification
The checker assumes the fetch side keeps the window unchanged until entries are popped. In particular, a long instruction stays in the head slot for the whole of its microcode stream. Without that, the head-lane and stream-progress properties would not be meaningful.

The stimulus models a fetch buffer. That buffer pops exactly the count the bench's own expectation computes, so every window it presents is the one a real fetch stage would present. Streams that reach an invalid head are cut short by clearing the buffer rather than by altering a window in flight.

// File: rtl/decGroupPkg.sv
package decGroupPkg;
  // Strobes from the steering control to the lane datapath
  typedef struct packed {
    logic issueGroup;  // normal group from the window this cycle
    logic ucIssue;     // microcode chunk on the head lanes
    logic ucLast;      // chunk carries the final micro-operation
    logic hold;        // downstream stall, nothing pops
  } steerCtrl_t;
endpackage

// File: rtl/decGroupCtrl.sv
module decGroupCtrl
  import decGroupPkg::*;
#(
  parameter int CNT_W       = 6,
  parameter int COMPLEX_MAX = 4
) (
  input  logic             clk,
  input  logic             rstN,
  input  logic [CNT_W-1:0] headUops,
  input  logic             stallIn,
  output steerCtrl_t       ctrl,
  output logic [CNT_W-1:0] ucBase,
  output logic             ucActive
);
  localparam logic [CNT_W-1:0] CPLX_LIM = CNT_W'(COMPLEX_MAX);

  logic [CNT_W-1:0] ucNext;
  logic [CNT_W-1:0] remain;
  logic             headLong;

  always_comb begin
    headLong        = headUops > CPLX_LIM;
    ucBase          = ucActive ? ucNext : '0;
    remain          = headUops - ucBase;
    ctrl.ucIssue    = ucActive || headLong;
    ctrl.ucLast     = ctrl.ucIssue && (remain <= CPLX_LIM);
    ctrl.issueGroup = !ctrl.ucIssue && (headUops != '0);
    ctrl.hold       = stallIn;
  end

  always_ff @(posedge clk) begin
    if (!rstN) begin
      ucActive <= 1'b0;
      ucNext   <= '0;
    end else if (!stallIn && ctrl.ucIssue) begin
      if (ctrl.ucLast) begin
        ucActive <= 1'b0;
        ucNext   <= '0;
      end else begin
        ucActive <= 1'b1;
        ucNext   <= ucBase + CPLX_LIM;
      end
    end
  end
endmodule

// File: rtl/decGroupPath.sv
module decGroupPath
  import decGroupPkg::*;
#(
  parameter int WIN         = 4,
  parameter int CNT_W       = 6,
  parameter int COMPLEX_MAX = 4,
  localparam int LANES      = COMPLEX_MAX + WIN - 1,
  localparam int CONS_W     = $clog2(WIN + 1)
) (
  input  logic [WIN-1:0][CNT_W-1:0]   instUops,
  input  steerCtrl_t                  ctrl,
  input  logic [CNT_W-1:0]            ucBase,
  output logic [LANES-1:0]            uopValid,
  output logic [LANES-1:0][CNT_W-1:0] uopIdx,
  output logic [CONS_W-1:0]           consumeCnt
);
  logic [CNT_W-1:0] remain;
  logic [WIN-1:0]   take;
  logic [CONS_W-1:0] groupLen;

  assign remain = instUops[0] - ucBase;

  // head-slot lanes: either a complex expansion or a microcode chunk
  for (genvar l = 0; l < COMPLEX_MAX; l++) begin : g_headLane
    always_comb begin
      if (ctrl.ucIssue) begin
        uopValid[l] = CNT_W'(l) < remain;
        uopIdx[l]   = ucBase + CNT_W'(l);
      end else if (ctrl.issueGroup) begin
        uopValid[l] = CNT_W'(l) < instUops[0];
        uopIdx[l]   = CNT_W'(l);
      end else begin
        uopValid[l] = 1'b0;
        uopIdx[l]   = '0;
      end
    end
  end

  // trailing slots: contiguous run of single-uop entries
  assign take[0] = ctrl.issueGroup;
  for (genvar k = 1; k < WIN; k++) begin : g_simpleLane
    assign take[k] = take[k-1] && (instUops[k] == CNT_W'(1));
    assign uopValid[COMPLEX_MAX-1+k] = take[k];
    assign uopIdx[COMPLEX_MAX-1+k]   = '0;
  end

  always_comb begin
    groupLen = '0;
    for (int k = 0; k < WIN; k++) groupLen = groupLen + CONS_W'(take[k]);
    if (ctrl.hold)            consumeCnt = '0;
    else if (ctrl.issueGroup) consumeCnt = groupLen;
    else if (ctrl.ucLast)     consumeCnt = CONS_W'(1);
    else                      consumeCnt = '0;
  end
endmodule

// File: rtl/decGroupSteer.sv
module decGroupSteer
  import decGroupPkg::*;
#(
  parameter int WIN         = 4,
  parameter int CNT_W       = 6,
  parameter int COMPLEX_MAX = 4,
  localparam int LANES      = COMPLEX_MAX + WIN - 1,
  localparam int CONS_W     = $clog2(WIN + 1)
) (
  input  logic                        clk,
  input  logic                        rstN,
  input  logic [WIN-1:0][CNT_W-1:0]   instUops,
  input  logic                        stallIn,
  output logic [LANES-1:0]            uopValid,
  output logic [LANES-1:0][CNT_W-1:0] uopIdx,
  output logic [CONS_W-1:0]           consumeCnt
);
  steerCtrl_t       ctrl;
  logic [CNT_W-1:0] ucBase;
  logic             ucActive;

  decGroupCtrl #(.CNT_W(CNT_W), .COMPLEX_MAX(COMPLEX_MAX)) ctrl_i (
    .clk(clk), .rstN(rstN), .headUops(instUops[0]), .stallIn(stallIn),
    .ctrl(ctrl), .ucBase(ucBase), .ucActive(ucActive)
  );

  decGroupPath #(.WIN(WIN), .CNT_W(CNT_W), .COMPLEX_MAX(COMPLEX_MAX)) path_i (
    .instUops(instUops), .ctrl(ctrl), .ucBase(ucBase),
    .uopValid(uopValid), .uopIdx(uopIdx), .consumeCnt(consumeCnt)
  );
endmodule

// File: rtl/decGroupSteerChk.sv
module decGroupSteerChk #(
  parameter int WIN         = 4,
  parameter int CNT_W       = 6,
  parameter int COMPLEX_MAX = 4,
  localparam int LANES      = COMPLEX_MAX + WIN - 1,
  localparam int CONS_W     = $clog2(WIN + 1)
) (
  input logic                      clk,
  input logic                      rstN,
  input logic                      stallIn,
  input logic [WIN-1:0][CNT_W-1:0] instUops,
  input logic [LANES-1:0]          uopValid,
  input logic [CONS_W-1:0]         consumeCnt,
  input logic                      ucActive,
  input logic [CNT_W-1:0]          ucBase
);
  // R7
  stall_no_pop_chk: assert property (@(posedge clk) disable iff (!rstN)
    stallIn |-> consumeCnt == '0);

  // R7
  stall_hold_chk: assert property (@(posedge clk) disable iff (!rstN)
    stallIn |=> (ucActive == $past(ucActive)) && (ucBase == $past(ucBase)));

  // R6
  uc_quiet_chk: assert property (@(posedge clk) disable iff (!rstN)
    ucActive |-> (uopValid[LANES-1:COMPLEX_MAX] == '0) && (consumeCnt <= CONS_W'(1)));

  // R6
  uc_step_chk: assert property (@(posedge clk) disable iff (!rstN)
    (!stallIn && ucActive && consumeCnt == '0)
      |=> ucActive && (ucBase == CNT_W'($past(ucBase) + CNT_W'(COMPLEX_MAX))));

  // R5
  head_lane_chk: assert property (@(posedge clk) disable iff (!rstN)
    uopValid[0] == (instUops[0] != '0));

  // R2
  pop_bound_chk: assert property (@(posedge clk) disable iff (!rstN)
    consumeCnt <= CONS_W'(WIN));

  // R4
  for (genvar k = 1; k < WIN - 1; k++) begin : g_contig
    simple_contig_chk: assert property (@(posedge clk) disable iff (!rstN)
      uopValid[COMPLEX_MAX+k] |-> uopValid[COMPLEX_MAX+k-1]);
  end
endmodule

bind decGroupSteer decGroupSteerChk #(.WIN(WIN), .CNT_W(CNT_W), .COMPLEX_MAX(COMPLEX_MAX)) chk_i (
  .clk(clk), .rstN(rstN), .stallIn(stallIn), .instUops(instUops),
  .uopValid(uopValid), .consumeCnt(consumeCnt), .ucActive(ucActive), .ucBase(ucBase)
);

// File: tb/decGroupSteer_tb_top.sv
`timescale 1ns/1ps
module decGroupSteer_tb_top;
  localparam int WIN = 4, CNT_W = 6, CM = 4, LANES = 7, CONS_W = 3;

  logic clk = 1'b0, rstN = 1'b0, stallIn = 1'b0;
  logic [WIN-1:0][CNT_W-1:0]   instUops = '0;
  logic [LANES-1:0]            uopValid;
  logic [LANES-1:0][CNT_W-1:0] uopIdx;
  logic [CONS_W-1:0]           consumeCnt;

  decGroupSteer dut_i (.clk(clk), .rstN(rstN), .instUops(instUops), .stallIn(stallIn),
                       .uopValid(uopValid), .uopIdx(uopIdx), .consumeCnt(consumeCnt));

  always #2.5 clk = ~clk;

  typedef struct {
    logic [LANES-1:0]            v;
    logic [LANES-1:0][CNT_W-1:0] idx;
    int                          cons;
    string                       tag;
  } exp_t;

  exp_t sb[$];
  int   fetchQ[$];
  int   nRun = 0, nFail = 0;
  bit   mUc = 0;
  int   mNext = 0;
  bit   done = 0;

  // driver: present window, predict, push, pop fetch buffer, advance model
  task automatic step(input bit st, input string tag);
    exp_t e;
    int   w[WIN];
    @(negedge clk);
    for (int i = 0; i < WIN; i++) w[i] = (i < fetchQ.size()) ? fetchQ[i] : 0;
    for (int i = 0; i < WIN; i++) instUops[i] = CNT_W'(w[i]);
    stallIn = st;
    e.v = '0; e.idx = '0; e.cons = 0; e.tag = tag;
    if (mUc || w[0] > CM) begin
      int base = mUc ? mNext : 0;
      int left = w[0] - base;
      for (int l = 0; l < CM; l++)
        if (l < left) begin e.v[l] = 1'b1; e.idx[l] = CNT_W'(base + l); end
      if (!st) begin
        if (left <= CM) begin e.cons = 1; mUc = 0; mNext = 0; end
        else begin mUc = 1; mNext = base + CM; end
      end
    end else if (w[0] != 0) begin
      int n = 1;
      for (int l = 0; l < w[0]; l++) begin e.v[l] = 1'b1; e.idx[l] = CNT_W'(l); end
      for (int k = 1; k < WIN; k++) begin
        if (n != k || w[k] != 1) break;
        e.v[CM-1+k] = 1'b1;
        n++;
      end
      if (!st) e.cons = n;
    end
    sb.push_back(e);
    for (int c = 0; c < e.cons; c++) void'(fetchQ.pop_front());
  endtask

  // monitor
  always @(negedge clk) begin
    #1;
    if (sb.size() > 0) begin
      exp_t e;
      bit   bad;
      e = sb.pop_front();
      bad = (uopValid !== e.v) || (consumeCnt !== CONS_W'(e.cons));
      for (int l = 0; l < LANES; l++)
        if (e.v[l] && uopIdx[l] !== e.idx[l]) bad = 1;
      nRun++;
      if (bad) begin
        nFail++;
        $display("FAIL %s: actual valid=%b idx=%h consume=%0d expected valid=%b idx=%h consume=%0d",
                 e.tag, uopValid, uopIdx, consumeCnt, e.v, e.idx, e.cons);
      end
    end
  end

  task automatic runSeq(input string tag, input int stallMask, input int maxSteps);
    for (int i = 0; i < maxSteps && fetchQ.size() > 0; i++) step(stallMask[i], tag);
  endtask

  task automatic doReset();
    @(negedge clk);
    rstN = 1'b0; stallIn = 1'b0; instUops = '0;
    mUc = 0; mNext = 0;
    repeat (3) @(negedge clk);
    rstN = 1'b1;
  endtask

  initial begin
    doReset();
    // R5 idle window after reset: nothing valid, nothing popped
    step(1'b0, "R5 reset-idle");
    // R2 four simple then two simple
    fetchQ = '{1, 1, 1, 1, 1, 1};
    runSeq("R2 simple-run", 0, 10);
    // R3 complex head with simple tail, then full-width complex
    fetchQ = '{3, 1, 1, 1, 4, 1, 2};
    runSeq("R3 complex-head", 0, 10);
    // R4 group cut before non-simple trailing entries
    fetchQ = '{1, 2, 1, 1, 1, 1, 5, 1, 1};
    runSeq("R4 group-cut", 0, 12);
    // R4 R5 zero count terminates the group and blocks at head
    fetchQ = '{1, 1, 0, 1};
    runSeq("R4 R5 zero-entry", 0, 3);
    fetchQ.delete();
    // R6 streams of several lengths incl. exact multiples
    fetchQ = '{10, 1, 8, 5, 1, 1};
    runSeq("R6 ucode-stream", 0, 20);
    fetchQ = '{23, 2};
    runSeq("R6 long-stream", 0, 20);
    // R7 stalls in mid-stream and on a normal group
    fetchQ = '{9, 1, 1};
    runSeq("R7 stall-ucode", 32'b0110, 20);
    fetchQ = '{1, 1, 1, 3};
    runSeq("R7 stall-group", 32'b0011, 20);
    // R1 reset in the middle of a stream restarts it at index 0
    fetchQ = '{12, 1};
    step(1'b0, "R1 pre-reset");
    step(1'b0, "R1 pre-reset");
    doReset();
    runSeq("R1 restart", 0, 20);
    repeat (3) @(negedge clk);
    done = 1;
    $display("  [TB] %0d tests run, %0d failed", nRun, nFail);
    $finish;
  end

  initial begin
    #(100000 * 5);
    if (!done) begin
      nFail++;
      $display("FAIL watchdog: actual=hung expected=finished");
      $display("  [TB] %0d tests run, %0d failed", nRun, nFail);
      $finish;
    end
  end
endmodule